// File: doc/BRIEF.md
# Exception Priority and Vector Selector

This block sits beside a processor core and decides which pending exception the core takes next. It watches five request sources: reset, the non-maskable interrupt, machine check, floating-point-unavailable and decrementer. It gates each source with the enable it depends on. The source with the highest priority wins, and the block registers that source's vector offset. A one-cycle take strobe marks the new vector, and the block holds the vector until the core acknowledges it.

Reset and the non-maskable interrupt share one vector, so a registered cause bit tells the service code which of the two caused the entry. A machine-check fault that arrives while checking is disabled does not vector. Instead it drives the block into a checkstop state, and only a reset request releases that state.

Top module: `exc_vector_sel`

## Requirements
- R1: After the asynchronous reset `rstN` is released, `takePulse`, `vecValid`, `causeNmi`, `checkstop` and `eeClear` are 0 and `vecOffset` is 0x000.
- R2: A reset request is always taken with offset 0x100 and `causeNmi`=0. This holds even while a vector is held or a checkstop is active, and taking it clears `checkstop`.
- R3: A non-maskable interrupt request is taken with offset 0x100 and `causeNmi`=1, whatever the values of `mchkEnable`, `extIntEnable` and `fpEnabled`.
- R4: A machine-check request with `mchkEnable`=1 is taken with offset 0x200.
- R5: A machine-check request with `mchkEnable`=0 and no reset request takes nothing and sets `checkstop` one cycle later. This takes precedence over every source except reset. `checkstop` then stays set, and no non-reset exception is taken, until a reset request arrives.
- R6: `instIsFp`=1 with `fpEnabled`=0 is taken with offset 0x800. With `fpEnabled`=1 it takes nothing.
- R7: A decrementer request is taken with offset 0x900 only when `extIntEnable`=1. Otherwise it takes nothing.
- R8: When several sources are eligible in the same cycle, the winner follows this fixed order: reset, non-maskable interrupt, machine check, floating-point-unavailable, decrementer.
- R9: A request sampled at one rising edge appears at that edge's registered outputs. `takePulse` and `eeClear` are high for exactly that one cycle per take.
- R10: Once a vector is taken, `vecOffset` and `vecValid`=1 are held and no non-reset exception is taken until `ack`. `ack` clears `vecValid` at the next edge, and `vecOffset` and `causeNmi` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| reqReset | input | 1 | Reset exception request |
| reqNmi | input | 1 | Non-maskable interrupt request |
| reqMchk | input | 1 | Machine-check fault |
| mchkEnable | input | 1 | Machine-check exceptions enabled |
| instIsFp | input | 1 | Issuing instruction is floating point |
| fpEnabled | input | 1 | Floating-point unit enabled |
| reqDec | input | 1 | Decrementer request |
| extIntEnable | input | 1 | Maskable exceptions enabled |
| ack | input | 1 | Core has consumed the held vector |
| takePulse | output | 1 | One-cycle strobe on a new take |
| vecOffset | output | 12 | Held vector offset |
| vecValid | output | 1 | A taken vector is awaiting ack |
| causeNmi | output | 1 | Last 0x100 entry came from the non-maskable interrupt |
| checkstop | output | 1 | Sticky checkstop state |
| eeClear | output | 1 | Strobe telling the core to clear its maskable-enable bit |

## Verification
Every result of this block appears exactly one rising edge after the inputs that cause it are sampled. This covers the take strobe, the vector, the cause bit, the clearing of the valid flag on ack, and entry into or exit from checkstop. The driver changes inputs on the falling edge and queues the expected outputs for the next rising edge. The monitor compares them one time unit after that edge, so each check lands on the first cycle in which its result is due. Hold cycles and ignored requests are checked the same way, against the output values that must persist.

// File: rtl/exc_sel_pkg.sv
package exc_sel_pkg;
  typedef enum logic [2:0] {
    KIND_NONE = 3'd0,
    KIND_RST  = 3'd1,
    KIND_NMI  = 3'd2,
    KIND_MC   = 3'd3,
    KIND_FPU  = 3'd4,
    KIND_DEC  = 3'd5
  } excKind_t;

  typedef struct packed {
    logic     take;
    excKind_t kind;
    logic     setCs;
    logic     clrCs;
    logic     clrValid;
  } ctrlStrobe_t;
endpackage

// File: rtl/exc_sel_ctrl.sv
module exc_sel_ctrl
  import exc_sel_pkg::*;
(
  input  logic        reqReset,
  input  logic        reqNmi,
  input  logic        reqMchk,
  input  logic        mchkEnable,
  input  logic        instIsFp,
  input  logic        fpEnabled,
  input  logic        reqDec,
  input  logic        extIntEnable,
  input  logic        ack,
  input  logic        busy,
  input  logic        inCheckstop,
  output ctrlStrobe_t strobe
);
  logic csEvent;
  logic canTake;

  assign csEvent = reqMchk & ~mchkEnable & ~reqReset;
  assign canTake = ~busy & ~inCheckstop & ~csEvent;

  always_comb begin
    strobe          = '0;
    strobe.kind     = KIND_NONE;
    strobe.clrValid = ack;
    if (reqReset) begin
      strobe.take  = 1'b1;
      strobe.kind  = KIND_RST;
      strobe.clrCs = 1'b1;
    end else if (csEvent) begin
      strobe.setCs = 1'b1;
    end else if (canTake) begin
      if (reqNmi) begin
        strobe.take = 1'b1;
        strobe.kind = KIND_NMI;
      end else if (reqMchk && mchkEnable) begin
        strobe.take = 1'b1;
        strobe.kind = KIND_MC;
      end else if (instIsFp && !fpEnabled) begin
        strobe.take = 1'b1;
        strobe.kind = KIND_FPU;
      end else if (reqDec && extIntEnable) begin
        strobe.take = 1'b1;
        strobe.kind = KIND_DEC;
      end
    end
  end
endmodule

// File: rtl/exc_sel_dp.sv
module exc_sel_dp
  import exc_sel_pkg::*;
#(
  parameter int VEC_W   = 12,
  parameter int OFF_RST = 'h100,
  parameter int OFF_MC  = 'h200,
  parameter int OFF_FPU = 'h800,
  parameter int OFF_DEC = 'h900
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  output logic             takeQ,
  output logic [VEC_W-1:0] vecQ,
  output logic             validQ,
  output logic             nmiQ,
  output logic             csQ
);
  logic [VEC_W-1:0] vecNext;

  always_comb begin
    unique case (strobe.kind)
      KIND_RST, KIND_NMI: vecNext = VEC_W'(OFF_RST);
      KIND_MC:            vecNext = VEC_W'(OFF_MC);
      KIND_FPU:           vecNext = VEC_W'(OFF_FPU);
      KIND_DEC:           vecNext = VEC_W'(OFF_DEC);
      default:            vecNext = vecQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      takeQ  <= 1'b0;
      vecQ   <= '0;
      validQ <= 1'b0;
      nmiQ   <= 1'b0;
      csQ    <= 1'b0;
    end else begin
      takeQ <= strobe.take;
      if (strobe.take) begin
        vecQ   <= vecNext;
        nmiQ   <= (strobe.kind == KIND_NMI);
        validQ <= 1'b1;
      end else if (strobe.clrValid) begin
        validQ <= 1'b0;
      end
      if (strobe.clrCs)      csQ <= 1'b0;
      else if (strobe.setCs) csQ <= 1'b1;
    end
  end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_sel_pkg::*;
#(
  parameter int VEC_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqReset,
  input  logic             reqNmi,
  input  logic             reqMchk,
  input  logic             mchkEnable,
  input  logic             instIsFp,
  input  logic             fpEnabled,
  input  logic             reqDec,
  input  logic             extIntEnable,
  input  logic             ack,
  output logic             takePulse,
  output logic [VEC_W-1:0] vecOffset,
  output logic             vecValid,
  output logic             causeNmi,
  output logic             checkstop,
  output logic             eeClear
);
  ctrlStrobe_t strobe;

  exc_sel_ctrl ctrl_i (
    .reqReset    (reqReset),
    .reqNmi      (reqNmi),
    .reqMchk     (reqMchk),
    .mchkEnable  (mchkEnable),
    .instIsFp    (instIsFp),
    .fpEnabled   (fpEnabled),
    .reqDec      (reqDec),
    .extIntEnable(extIntEnable),
    .ack         (ack),
    .busy        (vecValid),
    .inCheckstop (checkstop),
    .strobe      (strobe)
  );

  exc_sel_dp #(.VEC_W(VEC_W)) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .takeQ (takePulse),
    .vecQ  (vecOffset),
    .validQ(vecValid),
    .nmiQ  (causeNmi),
    .csQ   (checkstop)
  );

  assign eeClear = takePulse;
endmodule

// File: rtl/exc_vector_sel_chk.sv
module exc_vector_sel_chk #(
  parameter int VEC_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqReset,
  input logic             reqNmi,
  input logic             reqMchk,
  input logic             mchkEnable,
  input logic             ack,
  input logic             takePulse,
  input logic [VEC_W-1:0] vecOffset,
  input logic             vecValid,
  input logic             causeNmi,
  input logic             checkstop
);
  // R2: a reset request always produces a take at the next edge
  a_r2_reset_taken: assert property (@(posedge clk) disable iff (!rstN)
    reqReset |=> takePulse && !causeNmi && !checkstop && vecOffset == VEC_W'('h100));

  // R3: an NMI with no reset and no checkstop cause, while idle, is taken
  a_r3_nmi_taken: assert property (@(posedge clk) disable iff (!rstN)
    reqNmi && !reqReset && !vecValid && !checkstop && !(reqMchk && !mchkEnable)
    |=> takePulse && causeNmi && vecOffset == VEC_W'('h100));

  // R5: checkstop is sticky without a reset request
  a_r5_cs_sticky: assert property (@(posedge clk) disable iff (!rstN)
    checkstop && !reqReset |=> checkstop && !takePulse);

  // R5: checkstop rises only after a disabled machine check
  a_r5_cs_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(checkstop) |-> $past(reqMchk && !mchkEnable) && !takePulse);

  // R10: the held vector stays put until ack
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    vecValid && !ack && !reqReset |=> vecValid && $stable(vecOffset) && !takePulse);

  // R9: a take always leaves a valid vector
  a_r9_take_valid: assert property (@(posedge clk) disable iff (!rstN)
    takePulse |-> vecValid);
endmodule

bind exc_vector_sel exc_vector_sel_chk #(.VEC_W(VEC_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .reqReset  (reqReset),
  .reqNmi    (reqNmi),
  .reqMchk   (reqMchk),
  .mchkEnable(mchkEnable),
  .ack       (ack),
  .takePulse (takePulse),
  .vecOffset (vecOffset),
  .vecValid  (vecValid),
  .causeNmi  (causeNmi),
  .checkstop (checkstop)
);

// File: tb/exc_vector_sel_tb.sv
module exc_vector_sel_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqReset = 0, reqNmi = 0, reqMchk = 0, mchkEnable = 0;
  logic instIsFp = 0, fpEnabled = 0, reqDec = 0, extIntEnable = 0, ack = 0;
  logic takePulse, vecValid, causeNmi, checkstop, eeClear;
  logic [11:0] vecOffset;

  typedef struct {
    logic        take;
    logic [11:0] vec;
    logic        valid;
    logic        nmi;
    logic        cs;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_vector_sel dut_i (
    .clk(clk), .rstN(rstN), .reqReset(reqReset), .reqNmi(reqNmi),
    .reqMchk(reqMchk), .mchkEnable(mchkEnable), .instIsFp(instIsFp),
    .fpEnabled(fpEnabled), .reqDec(reqDec), .extIntEnable(extIntEnable),
    .ack(ack), .takePulse(takePulse), .vecOffset(vecOffset),
    .vecValid(vecValid), .causeNmi(causeNmi), .checkstop(checkstop),
    .eeClear(eeClear)
  );

  task automatic compareNow(input expItem_t e);
    checks++;
    if (takePulse !== e.take || eeClear !== e.take || vecOffset !== e.vec ||
        vecValid !== e.valid || causeNmi !== e.nmi || checkstop !== e.cs) begin
      fails++;
      $display("FAIL %s: got take=%b ee=%b vec=%h valid=%b nmi=%b cs=%b, exp take=%b ee=%b vec=%h valid=%b nmi=%b cs=%b",
               e.tag, takePulse, eeClear, vecOffset, vecValid, causeNmi, checkstop,
               e.take, e.take, e.vec, e.valid, e.nmi, e.cs);
    end
  endtask

  // monitor: compares one time unit after each rising edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) compareNow(expQ.pop_front());
  end

  // driver: inputs change on the falling edge, expectation due at next rising edge
  task automatic drive(input logic rr, nm, mc, mce, fpi, fpe, dc, ee, ak,
                       input logic eTake, input logic [11:0] eVec,
                       input logic eValid, eNmi, eCs, input string tag);
    expItem_t e;
    @(negedge clk);
    reqReset = rr; reqNmi = nm; reqMchk = mc; mchkEnable = mce;
    instIsFp = fpi; fpEnabled = fpe; reqDec = dc; extIntEnable = ee; ack = ak;
    e.take = eTake; e.vec = eVec; e.valid = eValid; e.nmi = eNmi; e.cs = eCs; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout, exp completion");
    finish();
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    // R1: reset state before release
    begin
      expItem_t r;
      r.take = 0; r.vec = 12'h000; r.valid = 0; r.nmi = 0; r.cs = 0; r.tag = "R1";
      compareNow(r);
    end
    rstN = 1'b1;
    //     rr nm mc mce fi fe dc ee ak | take vec   val nmi cs
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0,   0, 12'h000, 0, 0, 0, "R1 idle");
    drive(0, 0, 0, 0, 0, 0, 1, 0, 0,   0, 12'h000, 0, 0, 0, "R7 masked dec");
    drive(0, 0, 0, 0, 1, 1, 0, 0, 0,   0, 12'h000, 0, 0, 0, "R6 fp enabled");
    drive(0, 0, 0, 0, 0, 0, 1, 1, 0,   1, 12'h900, 1, 0, 0, "R7 dec taken");
    drive(0, 0, 0, 0, 0, 0, 1, 1, 0,   0, 12'h900, 1, 0, 0, "R9 R10 hold");
    drive(0, 0, 0, 0, 1, 0, 0, 0, 1,   0, 12'h900, 0, 0, 0, "R10 ack");
    drive(0, 0, 0, 0, 1, 0, 0, 0, 0,   1, 12'h800, 1, 0, 0, "R6 fp unavailable");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1,   0, 12'h800, 0, 0, 0, "R10 ack");
    drive(0, 0, 1, 1, 0, 0, 0, 0, 0,   1, 12'h200, 1, 0, 0, "R4 machine check");
    drive(0, 0, 0, 1, 0, 0, 0, 0, 1,   0, 12'h200, 0, 0, 0, "R10 ack");
    drive(0, 1, 0, 0, 0, 1, 0, 0, 0,   1, 12'h100, 1, 1, 0, "R3 nmi unmasked");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1,   0, 12'h100, 0, 1, 0, "R10 ack keeps cause");
    drive(0, 1, 1, 1, 1, 0, 1, 1, 0,   1, 12'h100, 1, 1, 0, "R8 nmi first");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1,   0, 12'h100, 0, 1, 0, "R10 ack");
    drive(0, 0, 1, 1, 1, 0, 1, 1, 0,   1, 12'h200, 1, 0, 0, "R8 mchk over fp");
    drive(0, 0, 0, 1, 0, 0, 0, 0, 1,   0, 12'h200, 0, 0, 0, "R10 ack");
    drive(0, 0, 0, 0, 1, 0, 1, 1, 0,   1, 12'h800, 1, 0, 0, "R8 fp over dec");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1,   0, 12'h800, 0, 0, 0, "R10 ack");
    drive(1, 1, 0, 0, 0, 0, 0, 0, 0,   1, 12'h100, 1, 0, 0, "R2 R8 reset over nmi");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1,   0, 12'h100, 0, 0, 0, "R10 ack");
    drive(0, 0, 0, 0, 0, 0, 1, 1, 0,   1, 12'h900, 1, 0, 0, "R7 dec taken");
    drive(1, 0, 0, 0, 0, 0, 0, 0, 0,   1, 12'h100, 1, 0, 0, "R2 reset while held");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1,   0, 12'h100, 0, 0, 0, "R10 ack");
    drive(0, 0, 1, 0, 0, 0, 0, 0, 0,   0, 12'h100, 0, 0, 1, "R5 checkstop entry");
    drive(0, 1, 0, 0, 0, 0, 0, 0, 0,   0, 12'h100, 0, 0, 1, "R5 nmi blocked");
    drive(0, 0, 0, 0, 1, 0, 1, 1, 0,   0, 12'h100, 0, 0, 1, "R5 sticky");
    drive(1, 0, 0, 0, 0, 0, 0, 0, 0,   1, 12'h100, 1, 0, 0, "R2 reset leaves checkstop");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1,   0, 12'h100, 0, 0, 0, "R10 ack");
    drive(0, 1, 1, 0, 0, 0, 0, 0, 0,   0, 12'h100, 0, 0, 1, "R5 checkstop beats nmi");
    drive(1, 0, 0, 0, 0, 0, 0, 0, 1,   1, 12'h100, 1, 0, 0, "R2 reset with ack");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0,   0, 12'h100, 1, 0, 0, "R9 single pulse");
    @(negedge clk);
    reqReset = 0; reqNmi = 0; reqMchk = 0; instIsFp = 0; reqDec = 0; ack = 0;
    repeat (3) @(negedge clk);
    finish();
  end
endmodule